// File: doc/BRIEF.md
# Local Bus Ownership Controller

This block decides, clock by clock, whether a bus master drives its local bus, starts a new transfer, gives up the bus to another master, or is forced off the bus. Requests for bus transfers are queued as a count. While the count is non-zero, the controller opens a cycle with a one-clock active-low address strobe and then waits for a ready indication in the data phase. When the ready arrives, that cycle is complete and the count drops by one.

Two inputs can take the bus away. The first is an active-low back-off input. It aborts any cycle in flight at once and floats the bus from the next clock. When back-off is released, the aborted cycle is issued again from its address strobe, and a restart flag is raised with that strobe. The second is a hold request from another master. The controller grants it with a hold-acknowledge output, but only at a cycle boundary and never while the lock input marks a locked sequence. Back-off always wins over hold.

Top module: `bus_own_ctrl`

## Requirements
- R1: While reset is active and just after it, strobe_n is 1, breq is 0, hold_ack is 0, restart is 0, bus_drive is 1 and pend_cnt is 0.
- R2: Each req_push pulse adds one to pend_cnt. With pend_cnt non-zero and the bus idle, strobe_n goes to 0 for exactly one clock with breq at 1. A data phase follows, and a rdy seen there ends the cycle and lowers pend_cnt by one.
- R3: During the data phase, breq is 1 only when more than one request is counted. With a single pending request, breq is 0 before the cycle ends.
- R4: One clock after backoff_n is sampled 0, bus_drive is 0 and strobe_n is 1. This holds for as long as backoff_n stays 0. A rdy seen while backoff_n is 0 does not complete the cycle, and pend_cnt is unchanged.
- R5: In the clock after backoff_n returns to 1, an aborted cycle is started again with strobe_n at 0 and restart at 1. restart is 0 on every other strobe.
- R6: If hold_req is 1 when a cycle completes, or while the bus is idle, hold_ack is 1 and bus_drive is 0 from the next clock on. In hold and in back-off, breq is 1 exactly when pend_cnt is non-zero.
- R7: While lock_in is 1, hold_req is not granted at a cycle boundary, and the next pending cycle is started instead.
- R8: In the clock after hold_req is sampled 0 during a grant, hold_ack goes to 0 and bus_drive goes to 1 together.
- R9: When backoff_n is 0 and hold_req is 1 together, back-off is taken first and hold_ack stays 0. After release, the aborted cycle is replayed, and hold is granted when that cycle completes.
- R10: pend_cnt never goes above MAX_PEND (default 4). A req_push while the count is full, with no completion in that clock, is dropped.
- R11: strobe_n is never 0 while bus_drive is 0 or hold_ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_push | input | 1 | Adds one pending bus request |
| lock_in | input | 1 | High while a locked sequence is in progress |
| rdy | input | 1 | Cycle termination, sampled in the data phase |
| backoff_n | input | 1 | Active-low forced abort and float |
| hold_req | input | 1 | Another master asks for the bus |
| strobe_n | output | 1 | Active-low address strobe |
| breq | output | 1 | Bus request |
| hold_ack | output | 1 | Bus granted to the other master |
| bus_drive | output | 1 | High to drive the bus, low to float it |
| restart | output | 1 | Marks the strobe of a replayed cycle |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of requests not yet completed |

## Verification
The hardest case to reach is back-off landing in the data-phase clock while rdy and hold_req are both high. The controller must then drop the termination, keep the count, replay the cycle and only afterwards grant hold. The bench gets there by counting clocks from the strobe it sees and driving all three inputs on the exact falling edge of that data phase. A second hard case is the saturated queue. To fill it, the bench first parks the controller in a hold grant so that no cycle can drain the count, and then pushes more requests than the queue can hold.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_BACK  = 3'd3,
    ST_GRANT = 3'd4
  } own_state_t;
endpackage

// File: rtl/bus_rst_sync.sv
module bus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bus_req_counter.sv
module bus_req_counter #(
  parameter int MAX_PEND = 4,
  localparam int CW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          done,
  output logic [CW-1:0] count,
  output logic          have_pend,
  output logic          more_pend
);
  localparam logic [CW-1:0] FULL = CW'(MAX_PEND);

  logic [CW-1:0] count_q, count_d;
  logic          inc, dec, cnt_en;

  always_comb begin
    dec    = done && (count_q != '0);
    inc    = push && ((count_q != FULL) || dec);
    cnt_en = inc ^ dec;
    count_d = count_q;
    if (inc && !dec)      count_d = count_q + 1'b1;
    else if (dec && !inc) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count     = count_q;
  assign have_pend = (count_q != '0);
  assign more_pend = (count_q > CW'(1));
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       backoff_n,
  input  logic       hold_req,
  input  logic       lock_in,
  input  logic       rdy,
  input  logic       have_pend,
  input  logic       more_pend,
  output own_state_t state,
  output logic       replay,
  output logic       cyc_done
);
  own_state_t state_q, state_d;
  logic       replay_q, replay_d;
  logic       grant_ok;

  assign grant_ok = hold_req && !lock_in;

  always_comb begin
    state_d  = state_q;
    replay_d = replay_q;
    cyc_done = 1'b0;
    if (!backoff_n) begin
      state_d = ST_BACK;
      if (state_q == ST_ADDR || state_q == ST_DATA) replay_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (grant_ok)       state_d = ST_GRANT;
          else if (have_pend) state_d = ST_ADDR;
        end
        ST_ADDR: begin
          state_d  = ST_DATA;
          replay_d = 1'b0;
        end
        ST_DATA: begin
          if (rdy) begin
            cyc_done = 1'b1;
            if (grant_ok)       state_d = ST_GRANT;
            else if (more_pend) state_d = ST_ADDR;
            else                state_d = ST_IDLE;
          end
        end
        ST_BACK: begin
          if (replay_q)       state_d = ST_ADDR;
          else if (grant_ok)  state_d = ST_GRANT;
          else if (have_pend) state_d = ST_ADDR;
          else                state_d = ST_IDLE;
        end
        ST_GRANT: begin
          if (!hold_req) state_d = have_pend ? ST_ADDR : ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      replay_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      replay_q <= replay_d;
    end
  end

  assign state  = state_q;
  assign replay = replay_q;
endmodule

// File: rtl/bus_own_outs.sv
module bus_own_outs
  import bus_own_pkg::*;
(
  input  own_state_t state,
  input  logic       replay,
  input  logic       have_pend,
  input  logic       more_pend,
  output logic       strobe_n,
  output logic       breq,
  output logic       hold_ack,
  output logic       bus_drive,
  output logic       restart
);
  always_comb begin
    strobe_n  = 1'b1;
    breq      = 1'b0;
    hold_ack  = 1'b0;
    bus_drive = 1'b1;
    restart   = 1'b0;
    unique case (state)
      ST_ADDR: begin
        strobe_n = 1'b0;
        breq     = 1'b1;
        restart  = replay;
      end
      ST_DATA:  breq = more_pend;
      ST_BACK: begin
        bus_drive = 1'b0;
        breq      = have_pend;
      end
      ST_GRANT: begin
        bus_drive = 1'b0;
        hold_ack  = 1'b1;
        breq      = have_pend;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int MAX_PEND   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_push,
  input  logic          lock_in,
  input  logic          rdy,
  input  logic          backoff_n,
  input  logic          hold_req,
  output logic          strobe_n,
  output logic          breq,
  output logic          hold_ack,
  output logic          bus_drive,
  output logic          restart,
  output logic [CW-1:0] pend_cnt
);
  logic       rst_q_n;
  logic       have_pend, more_pend, cyc_done, replay;
  own_state_t state;

  bus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_q_n)
  );

  bus_req_counter #(.MAX_PEND(MAX_PEND)) u_cnt (
    .clk(clk), .rst_n(rst_q_n), .push(req_push), .done(cyc_done),
    .count(pend_cnt), .have_pend(have_pend), .more_pend(more_pend)
  );

  bus_own_fsm u_fsm (
    .clk(clk), .rst_n(rst_q_n), .backoff_n(backoff_n), .hold_req(hold_req),
    .lock_in(lock_in), .rdy(rdy), .have_pend(have_pend), .more_pend(more_pend),
    .state(state), .replay(replay), .cyc_done(cyc_done)
  );

  bus_own_outs u_outs (
    .state(state), .replay(replay), .have_pend(have_pend), .more_pend(more_pend),
    .strobe_n(strobe_n), .breq(breq), .hold_ack(hold_ack),
    .bus_drive(bus_drive), .restart(restart)
  );
endmodule

// File: rtl/bus_own_chk.sv
module bus_own_chk #(
  parameter int MAX_PEND = 4,
  localparam int CW = $clog2(MAX_PEND + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          backoff_n,
  input logic          hold_req,
  input logic          strobe_n,
  input logic          breq,
  input logic          hold_ack,
  input logic          bus_drive,
  input logic [CW-1:0] pend_cnt
);
  assert_no_strobe_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> (bus_drive && !hold_ack));

  assert_backoff_floats_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !backoff_n |=> (!bus_drive && strobe_n));

  assert_strobe_has_breq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> breq);

  assert_grant_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !bus_drive);

  assert_release_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && hold_req && backoff_n) |=> hold_ack);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CW'(MAX_PEND));

  assert_backoff_beats_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !backoff_n |=> !hold_ack);
endmodule

bind bus_own_ctrl bus_own_chk #(.MAX_PEND(MAX_PEND)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .backoff_n(backoff_n), .hold_req(hold_req),
  .strobe_n(strobe_n), .breq(breq), .hold_ack(hold_ack),
  .bus_drive(bus_drive), .pend_cnt(pend_cnt)
);

// File: tb/bus_own_ctrl_test.sv
module bus_own_ctrl_test;
  localparam int MAXP = 4;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n, req_push, lock_in, rdy, backoff_n, hold_req;
  logic strobe_n, breq, hold_ack, bus_drive, restart;
  logic [CW-1:0] pend_cnt;
  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  bus_own_ctrl #(.MAX_PEND(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .req_push(req_push), .lock_in(lock_in), .rdy(rdy),
    .backoff_n(backoff_n), .hold_req(hold_req), .strobe_n(strobe_n), .breq(breq),
    .hold_ack(hold_ack), .bus_drive(bus_drive), .restart(restart), .pend_cnt(pend_cnt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; req_push = 0; lock_in = 0; rdy = 0; backoff_n = 1; hold_req = 0;
    step(); step();
    chk("R1 strobe_n in reset", strobe_n, 1);
    rst_n = 1;
    step(); step(); step();
    chk("R1 strobe_n", strobe_n, 1);
    chk("R1 breq", breq, 0);
    chk("R1 hold_ack", hold_ack, 0);
    chk("R1 bus_drive", bus_drive, 1);
    chk("R1 restart", restart, 0);
    chk("R1 pend_cnt", pend_cnt, 0);
  endtask

  task automatic t_single();
    req_push = 1; step(); req_push = 0;
    chk("R2 count after push", pend_cnt, 1);
    step();
    chk("R2 strobe low", strobe_n, 0);
    chk("R2 breq with strobe", breq, 1);
    chk("R5 no restart on fresh cycle", restart, 0);
    step();
    chk("R2 strobe one clock", strobe_n, 1);
    chk("R3 breq low single pending", breq, 0);
    rdy = 1; step(); rdy = 0;
    chk("R2 count after ready", pend_cnt, 0);
    chk("R2 idle strobe", strobe_n, 1);
  endtask

  task automatic t_backoff();
    req_push = 1; step(); req_push = 0;
    step();
    chk("R2 strobe before backoff", strobe_n, 0);
    step();
    rdy = 1; backoff_n = 0; step();
    chk("R4 float next clock", bus_drive, 0);
    chk("R4 ready ignored", pend_cnt, 1);
    chk("R6 breq in backoff", breq, 1);
    rdy = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 stays floated", bus_drive, 0);
      chk("R4 no strobe", strobe_n, 1);
    end
    backoff_n = 1; step();
    chk("R5 replay strobe", strobe_n, 0);
    chk("R5 restart flag", restart, 1);
    step();
    chk("R5 restart one clock", restart, 0);
    rdy = 1; step(); rdy = 0;
    chk("R5 replay completes", pend_cnt, 0);
  endtask

  task automatic t_hold();
    req_push = 1; step(); step(); req_push = 0;
    chk("R2 two queued", pend_cnt, 2);
    chk("R2 strobe", strobe_n, 0);
    step();
    chk("R3 breq with more pending", breq, 1);
    hold_req = 1; rdy = 1; step(); rdy = 0;
    chk("R6 hold granted at boundary", hold_ack, 1);
    chk("R6 floated in grant", bus_drive, 0);
    chk("R6 breq in grant", breq, 1);
    step(); step();
    chk("R6 grant held", hold_ack, 1);
    hold_req = 0; step();
    chk("R8 hold_ack low", hold_ack, 0);
    chk("R8 drive resumed", bus_drive, 1);
    chk("R8 pending cycle starts", strobe_n, 0);
    step(); rdy = 1; step(); rdy = 0;
    chk("R2 drained", pend_cnt, 0);
  endtask

  task automatic t_lock();
    lock_in = 1;
    req_push = 1; step(); step(); req_push = 0;
    step();
    hold_req = 1; rdy = 1; step(); rdy = 0;
    chk("R7 no grant while locked", hold_ack, 0);
    chk("R7 next locked cycle", strobe_n, 0);
    step();
    lock_in = 0; rdy = 1; step(); rdy = 0;
    chk("R7 grant after lock ends", hold_ack, 1);
    hold_req = 0; step();
    chk("R8 release to idle", bus_drive, 1);
    chk("R8 idle no strobe", strobe_n, 1);
  endtask

  task automatic t_prio();
    req_push = 1; step(); req_push = 0;
    step(); step();
    hold_req = 1; backoff_n = 0; rdy = 1; step(); rdy = 0;
    chk("R9 backoff first", hold_ack, 0);
    chk("R9 floated", bus_drive, 0);
    backoff_n = 1; step();
    chk("R9 replay before grant", strobe_n, 0);
    chk("R9 replay restart", restart, 1);
    step(); rdy = 1; step(); rdy = 0;
    chk("R9 grant after replay", hold_ack, 1);
    chk("R9 replay completed", pend_cnt, 0);
    hold_req = 0; step();
    chk("R8 released", hold_ack, 0);
  endtask

  task automatic t_full();
    hold_req = 1; step();
    chk("R6 idle grant", hold_ack, 1);
    chk("R6 breq low no pending", breq, 0);
    req_push = 1;
    for (int i = 0; i < 6; i++) step();
    req_push = 0;
    chk("R10 saturated count", pend_cnt, MAXP);
    hold_req = 0; step();
    for (int i = 0; i < MAXP; i++) begin
      chk("R2 drain strobe", strobe_n, 0);
      step(); rdy = 1; step(); rdy = 0;
    end
    chk("R10 drained", pend_cnt, 0);
    chk("R10 no extra cycle", strobe_n, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_backoff();
    t_hold();
    t_lock();
    t_prio();
    t_full();
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule